// File: doc/BRIEF.md
# Serial Control Register Port

This block receives 16-bit control words over a three-wire serial link: a control clock, a data line and a latch strobe. All three lines are asynchronous to the system clock. The block passes them through a multi-flop synchroniser, detects their edges in the system clock domain and shifts in one data bit on each rising edge of the control clock, most significant bit first. A rising edge of the latch strobe commits the word to one of four registers, and only if a full word has been shifted since the previous latch.

The two least-significant bits of each word choose the target register. The first configuration register holds the power, mute, format, rate, de-emphasis, serial-format and word-width fields. The second configuration register holds the clock-ratio, zero-flag polarity and bitstream-interface fields. Two volume registers each hold a 14-bit unsigned attenuation value. Every field is available as a parallel output to the rest of the converter datapath. The software side cannot read any register back.

Top module: `scp_ctrl_port`

## Requirements
- R1: While `rst_n` is low, and after it rises, every configuration field output is 0 and both volume outputs are all ones (14'h3FFF, full volume).
- R2: Data is taken at each rising edge of `ctl_clk`, most significant bit first. Word bits [1:0] select the target register: 00 is configuration 0, 01 is configuration 1, 10 is left volume and 11 is right volume. A commit changes only the register it addresses.
- R3: Outputs do not change before the latch strobe rises. A valid commit is visible at the outputs no more than 4 system clock cycles after `ctl_lat` rises at the pin.
- R4: A latch rising edge is ignored, and all outputs keep their values, if fewer than 16 data bits were taken since reset or since the previous latch edge.
- R5: If more than 16 bits were shifted before the latch, the most recent 16 bits form the committed word.
- R6: Every latch rising edge clears the shift state, whether or not it commits. The next word therefore needs 16 new bits of its own.
- R7: Configuration 0 fields come from these word bits: `pwr_down` [15], `mute` [14], `data_fmt` [13:12], `out_fmt` [11:10], `pcm_rate` [9:8], `deemph` [7:6], `ser_fmt` [5:4], `word_width` [3:2].
- R8: Configuration 1 fields come from these word bits: `mclk_ratio` [10:9], `zero_pol` [8], `dsd_rate` [7], `dsd_phase_mode` [6], `phase_sel` [5:4], `bit_inv` [3], `mclk_edge` [2]. Word bits [15:11] are discarded.
- R9: A volume word carries the attenuation value in bits [15:2]. It goes to `vol_left` or `vol_right` according to the address, and the other channel is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_clk | input | 1 | Serial control clock, asynchronous |
| ctl_dat | input | 1 | Serial control data |
| ctl_lat | input | 1 | Latch strobe; its rising edge commits a word |
| pwr_down | output | 1 | Power-down request |
| mute | output | 1 | Soft mute request |
| data_fmt | output | 2 | Input data path select |
| out_fmt | output | 2 | Stereo/mono output select |
| pcm_rate | output | 2 | PCM sample rate band |
| deemph | output | 2 | De-emphasis curve select |
| ser_fmt | output | 2 | Serial audio format |
| word_width | output | 2 | Serial audio word width |
| mclk_ratio | output | 2 | Master clock ratio |
| zero_pol | output | 1 | Zero flag polarity |
| dsd_rate | output | 1 | Bitstream rate select |
| dsd_phase_mode | output | 1 | Bitstream normal/phase mode |
| phase_sel | output | 2 | Bitstream phase select |
| bit_inv | output | 1 | Bitstream bit inversion |
| mclk_edge | output | 1 | Master clock edge for bitstream clock |
| vol_left | output | 14 | Left attenuation value |
| vol_right | output | 14 | Right attenuation value |

## Verification
A wrong bit count or a stale shift register appears at the ports as a field update after a short word, or as a word displaced by one bit. Either is visible within four system cycles of the latch edge. A decode fault shows as an update in the wrong register or in two registers. Every latch edge is therefore followed by a comparison of all output fields against a model, so a fault is seen at the transfer that causes it.

// File: rtl/scp_pkg.sv
package scp_pkg;

   localparam int unsigned SCP_WORD_W = 16;
   localparam int unsigned SCP_ADDR_W = 2;
   localparam int unsigned SCP_VOL_W  = 14;

   typedef enum logic [1:0] {
      SEL_CFG0  = 2'b00,
      SEL_CFG1  = 2'b01,
      SEL_VOL_L = 2'b10,
      SEL_VOL_R = 2'b11
   } scp_sel_e;

   // occupies word bits [15:2]
   typedef struct packed {
      logic       pwr_down;
      logic       mute;
      logic [1:0] data_fmt;
      logic [1:0] out_fmt;
      logic [1:0] pcm_rate;
      logic [1:0] deemph;
      logic [1:0] ser_fmt;
      logic [1:0] word_width;
   } scp_cfg0_t;

   // occupies word bits [10:2]
   typedef struct packed {
      logic [1:0] mclk_ratio;
      logic       zero_pol;
      logic       dsd_rate;
      logic       dsd_phase_mode;
      logic [1:0] phase_sel;
      logic       bit_inv;
      logic       mclk_edge;
   } scp_cfg1_t;

endpackage

// File: rtl/scp_sync.sv
module scp_sync #(
   parameter int unsigned WIDTH  = 3,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_q,
   output logic [WIDTH-1:0] rise
);

   localparam int unsigned CHAIN = STAGES + 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("scp_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("scp_sync: WIDTH must be at least 1");
   end

   logic [CHAIN-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
      end else begin
         chain_q <= {chain_q[CHAIN-2:0], async_in};
      end
   end

   assign sync_q = chain_q[STAGES-1];

   for (genvar b = 0; b < WIDTH; b++) begin : g_edge
      assign rise[b] = chain_q[STAGES-1][b] & ~chain_q[STAGES][b];
   end

endmodule

// File: rtl/scp_shifter.sv
module scp_shifter #(
   parameter int unsigned WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en,
   input  logic              din,
   input  logic              clr,
   output logic [WORD_W-1:0] word,
   output logic              full
);

   localparam int unsigned CNT_W = $clog2(WORD_W + 1);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WORD_W);

   if (WORD_W < 4) begin : g_bad_word
      $error("scp_shifter: WORD_W too small");
   end

   logic [WORD_W-1:0] word_q;
   logic [CNT_W-1:0]  cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '0;
         cnt_q  <= '0;
      end else if (clr) begin
         word_q <= '0;
         cnt_q  <= '0;
      end else if (shift_en) begin
         word_q <= {word_q[WORD_W-2:0], din};
         if (cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign word = word_q;
   assign full = (cnt_q == CNT_MAX);

   AST_SHIFT_MSB_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_en && !clr) |=> (word_q[0] == $past(din)));  // R2

   AST_CLEAR_ON_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (!full && word_q == '0));  // R6

   AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !clr) |=> full);  // R5

endmodule

// File: rtl/scp_regfile.sv
module scp_regfile
   import scp_pkg::*;
#(
   parameter int unsigned WORD_W = SCP_WORD_W,
   parameter int unsigned ADDR_W = SCP_ADDR_W,
   parameter int unsigned VOL_W  = SCP_VOL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_word,
   output scp_cfg0_t         cfg0,
   output scp_cfg1_t         cfg1,
   output logic [VOL_W-1:0]  vol_l,
   output logic [VOL_W-1:0]  vol_r
);

   localparam int unsigned N_VOL   = 2;
   localparam int unsigned CFG0_W  = $bits(scp_cfg0_t);
   localparam int unsigned CFG1_W  = $bits(scp_cfg1_t);
   localparam logic [VOL_W-1:0] VOL_DEFAULT = '1;

   if (ADDR_W != 2) begin : g_bad_addr
      $error("scp_regfile: layout needs a 2-bit address");
   end
   if (WORD_W != CFG0_W + ADDR_W) begin : g_bad_word
      $error("scp_regfile: WORD_W does not match configuration layout");
   end
   if (VOL_W != WORD_W - ADDR_W) begin : g_bad_vol
      $error("scp_regfile: VOL_W must fill the word above the address");
   end

   logic [ADDR_W-1:0] addr;
   scp_cfg0_t         cfg0_q;
   scp_cfg1_t         cfg1_q;
   logic [VOL_W-1:0]  vol_q [N_VOL];

   assign addr = wr_word[ADDR_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg0_q <= '0;
      end else if (wr_en && addr == ADDR_W'(SEL_CFG0)) begin
         cfg0_q <= scp_cfg0_t'(wr_word[WORD_W-1:ADDR_W]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg1_q <= '0;
      end else if (wr_en && addr == ADDR_W'(SEL_CFG1)) begin
         cfg1_q <= scp_cfg1_t'(wr_word[ADDR_W +: CFG1_W]);
      end
   end

   for (genvar k = 0; k < N_VOL; k++) begin : g_vol
      localparam logic [ADDR_W-1:0] MY_SEL = ADDR_W'(SEL_VOL_L) + ADDR_W'(k);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vol_q[k] <= VOL_DEFAULT;
         end else if (wr_en && addr == MY_SEL) begin
            vol_q[k] <= wr_word[WORD_W-1:ADDR_W];
         end
      end
   end

   assign cfg0  = cfg0_q;
   assign cfg1  = cfg1_q;
   assign vol_l = vol_q[0];
   assign vol_r = vol_q[1];

   AST_CFG0_ONLY_ADDR0: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && addr == ADDR_W'(SEL_CFG0)) |=> $stable(cfg0_q));  // R2

   AST_VOL_L_ONLY_ADDR2: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && addr == ADDR_W'(SEL_VOL_L)) |=> $stable(vol_q[0]));  // R9

   AST_VOL_R_ONLY_ADDR3: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && addr == ADDR_W'(SEL_VOL_R)) |=> $stable(vol_q[1]));  // R9

endmodule

// File: rtl/scp_ctrl_port.sv
module scp_ctrl_port
   import scp_pkg::*;
#(
   parameter int unsigned WORD_W      = SCP_WORD_W,
   parameter int unsigned ADDR_W      = SCP_ADDR_W,
   parameter int unsigned VOL_W       = SCP_VOL_W,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_clk,
   input  logic             ctl_dat,
   input  logic             ctl_lat,
   output logic             pwr_down,
   output logic             mute,
   output logic [1:0]       data_fmt,
   output logic [1:0]       out_fmt,
   output logic [1:0]       pcm_rate,
   output logic [1:0]       deemph,
   output logic [1:0]       ser_fmt,
   output logic [1:0]       word_width,
   output logic [1:0]       mclk_ratio,
   output logic             zero_pol,
   output logic             dsd_rate,
   output logic             dsd_phase_mode,
   output logic [1:0]       phase_sel,
   output logic             bit_inv,
   output logic             mclk_edge,
   output logic [VOL_W-1:0] vol_left,
   output logic [VOL_W-1:0] vol_right
);

   localparam int unsigned N_LINES = 3;
   localparam int unsigned IDX_CLK = 0;
   localparam int unsigned IDX_DAT = 1;
   localparam int unsigned IDX_LAT = 2;

   logic [N_LINES-1:0] lines_sync;
   logic [N_LINES-1:0] lines_rise;
   logic               clk_rise;
   logic               lat_rise;
   logic [WORD_W-1:0]  word;
   logic               word_full;
   logic               commit;
   scp_cfg0_t          cfg0;
   scp_cfg1_t          cfg1;

   scp_sync #(
      .WIDTH  (N_LINES),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in ({ctl_lat, ctl_dat, ctl_clk}),
      .sync_q   (lines_sync),
      .rise     (lines_rise)
   );

   assign clk_rise = lines_rise[IDX_CLK];
   assign lat_rise = lines_rise[IDX_LAT];

   scp_shifter #(
      .WORD_W (WORD_W)
   ) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (clk_rise),
      .din      (lines_sync[IDX_DAT]),
      .clr      (lat_rise),
      .word     (word),
      .full     (word_full)
   );

   assign commit = lat_rise & word_full;

   scp_regfile #(
      .WORD_W (WORD_W),
      .ADDR_W (ADDR_W),
      .VOL_W  (VOL_W)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (commit),
      .wr_word (word),
      .cfg0    (cfg0),
      .cfg1    (cfg1),
      .vol_l   (vol_left),
      .vol_r   (vol_right)
   );

   assign pwr_down       = cfg0.pwr_down;
   assign mute           = cfg0.mute;
   assign data_fmt       = cfg0.data_fmt;
   assign out_fmt        = cfg0.out_fmt;
   assign pcm_rate       = cfg0.pcm_rate;
   assign deemph         = cfg0.deemph;
   assign ser_fmt        = cfg0.ser_fmt;
   assign word_width     = cfg0.word_width;
   assign mclk_ratio     = cfg1.mclk_ratio;
   assign zero_pol       = cfg1.zero_pol;
   assign dsd_rate       = cfg1.dsd_rate;
   assign dsd_phase_mode = cfg1.dsd_phase_mode;
   assign phase_sel      = cfg1.phase_sel;
   assign bit_inv        = cfg1.bit_inv;
   assign mclk_edge      = cfg1.mclk_edge;

   AST_SHORT_WORD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (lat_rise && !word_full) |=> ($stable(cfg0) && $stable(cfg1)
                                   && $stable(vol_left) && $stable(vol_right)));  // R4

   AST_NO_UPDATE_WITHOUT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      !lat_rise |=> ($stable(cfg0) && $stable(cfg1)
                     && $stable(vol_left) && $stable(vol_right)));  // R3

   AST_LATCH_EDGE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      lat_rise |=> !lat_rise);  // R6

endmodule

// File: tb/scp_ctrl_port_tb.sv
module scp_ctrl_port_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctl_clk = 1'b0;
   logic        ctl_dat = 1'b0;
   logic        ctl_lat = 1'b0;
   logic        pwr_down, mute, zero_pol, dsd_rate, dsd_phase_mode, bit_inv, mclk_edge;
   logic [1:0]  data_fmt, out_fmt, pcm_rate, deemph, ser_fmt, word_width, mclk_ratio, phase_sel;
   logic [13:0] vol_left, vol_right;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   logic [15:0] m_c0, m_c1;
   logic [13:0] m_vl, m_vr;

   always #2 clk = ~clk;

   scp_ctrl_port u_dut (
      .clk(clk), .rst_n(rst_n), .ctl_clk(ctl_clk), .ctl_dat(ctl_dat), .ctl_lat(ctl_lat),
      .pwr_down(pwr_down), .mute(mute), .data_fmt(data_fmt), .out_fmt(out_fmt),
      .pcm_rate(pcm_rate), .deemph(deemph), .ser_fmt(ser_fmt), .word_width(word_width),
      .mclk_ratio(mclk_ratio), .zero_pol(zero_pol), .dsd_rate(dsd_rate),
      .dsd_phase_mode(dsd_phase_mode), .phase_sel(phase_sel), .bit_inv(bit_inv),
      .mclk_edge(mclk_edge), .vol_left(vol_left), .vol_right(vol_right)
   );

   function automatic logic [50:0] expected();
      return {m_c0[15:2], m_c1[10:2], m_vl, m_vr};
   endfunction

   function automatic logic [50:0] actual();
      return {pwr_down, mute, data_fmt, out_fmt, pcm_rate, deemph, ser_fmt, word_width,
              mclk_ratio, zero_pol, dsd_rate, dsd_phase_mode, phase_sel, bit_inv, mclk_edge,
              vol_left, vol_right};
   endfunction

   task automatic model_reset();
      m_c0 = '0; m_c1 = '0; m_vl = '1; m_vr = '1;
   endtask

   task automatic model_write(input logic [15:0] w);
      case (w[1:0])
         2'b00: m_c0 = w;
         2'b01: m_c1 = w;
         2'b10: m_vl = w[15:2];
         default: m_vr = w[15:2];
      endcase
   endtask

   task automatic check(input string req);
      n_tests++;
      if (actual() !== expected()) begin
         n_fail++;
         $display("FAIL %s: actual=%h expected=%h", req, actual(), expected());
      end
   endtask

   task automatic send_bits(input logic [31:0] stream, input int len);
      for (int i = len - 1; i >= 0; i--) begin
         ctl_dat = stream[i];
         repeat (4) @(negedge clk);
         ctl_clk = 1'b1;
         repeat (4) @(negedge clk);
         ctl_clk = 1'b0;
      end
      repeat (4) @(negedge clk);
   endtask

   task automatic pulse_latch();
      ctl_lat = 1'b1;
      repeat (6) @(negedge clk);
      ctl_lat = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic xfer(input logic [31:0] stream, input int len);
      send_bits(stream, len);
      pulse_latch();
      if (len >= 16) model_write(stream[15:0]);
   endtask

   initial begin
      int unsigned seed_dummy;
      seed_dummy = $urandom(32'h5EED_C0DE);
      model_reset();
      repeat (3) @(negedge clk);
      check("R1 during reset");
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      check("R1 after reset");

      // R2/R7: configuration 0 alternating pattern
      xfer(32'h0000_A5A4, 16); check("R2 R7 cfg0 write");
      // R8: configuration 1, upper bits discarded
      xfer(32'h0000_FFFD, 16); check("R8 cfg1 write all ones");
      xfer(32'h0000_F9A5, 16); check("R8 cfg1 pattern");
      // R9: volumes, each channel separately
      xfer(32'h0000_1236, 16); check("R9 left volume");
      xfer(32'h0000_ABCF, 16); check("R9 right volume");
      xfer(32'h0000_0002, 16); check("R9 left volume zero");

      // R3: nothing changes before latch; update within 4 cycles
      send_bits(32'h0000_5A58, 16);
      check("R3 no update before latch");
      ctl_lat = 1'b1;
      repeat (4) @(negedge clk);
      model_write(16'h5A58);
      check("R3 commit latency");
      repeat (2) @(negedge clk);
      ctl_lat = 1'b0;
      repeat (4) @(negedge clk);

      // R4: short words and empty latches
      xfer(32'h0000_FFFC, 15); check("R4 15-bit word ignored");
      pulse_latch();           check("R4 latch without bits ignored");
      xfer(32'h0000_0003, 1);  check("R4 1-bit word ignored");

      // R5: longer streams, last 16 bits win
      xfer(32'h000F_0F0C, 20); check("R5 20-bit stream");
      xfer(32'h8000_7FFE, 32); check("R5 32-bit stream");

      // R6: full word committed, then 15 new bits must not reuse old ones
      xfer(32'h0000_C3C1, 16); check("R6 setup");
      xfer(32'h0000_3C3D, 15); check("R6 shift cleared by latch");

      // random mix
      for (int n = 0; n < 70; n++) begin
         logic [31:0] s;
         int          len;
         int          pick;
         s    = $urandom();
         pick = $urandom_range(0, 9);
         if (pick < 6)      len = 16;
         else if (pick < 8) len = $urandom_range(17, 24);
         else               len = $urandom_range(0, 15);
         xfer(s, len);
         if (len < 16)      check("R4 random short");
         else if (len > 16) check("R5 random long");
         else               check("R2 random word");
      end

      // R1: reset after writes restores defaults
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      model_reset();
      check("R1 mid-run reset");
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      check("R1 defaults held");

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(negedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule